// File: doc/BRIEF.md
# Key-Locked Watchdog Timer with Early-Warning Threshold

This block is a bus-mapped watchdog. A 32-bit down-counter advances by one step on each pulse of a slow tick enable. That enable stands for a 32768 Hz time base, so a timeout of N seconds takes a load value of N×32768. The counter carries two thresholds. When it falls to a programmable early-warning value, it raises an interrupt. When it reaches zero, it latches a reset event and asks the system for a reset.

Every register can be read at any time. All writes are refused until software writes the 16-bit unlock key 0xE551 to the lock register. Any other value written there relocks the block. Load and threshold values are written as two 16-bit halves. Writing either half starts a transfer window, shown by a busy status bit. When the window closes, the counter takes the new values. Rewriting the load value while the counter runs therefore serves as the keepalive. The slow clock domain is modelled by the tick enable inside one clock.

Software keeps the timeout between 3 and 60 seconds. It also keeps the early-warning value at or above 3 seconds of steps.

Top module: `kwdt_top`

## Requirements
- R1: After reset, all registers read zero, the block is locked (lock register bit 0 reads 0), and irq and rst_req are low.
- R2: A write of exactly 0xE551 to offset 0x20 unlocks the block, and lock register bit 0 reads 1. A write of any other value to 0x20 locks it, and the bit reads 0.
- R3: While the block is locked, a write to any offset other than 0x20 changes no register and no status bit.
- R4: Value layout:
  - The load value is split across 0x00 (bits 15:0) and 0x04 (bits 31:16).
  - The early-warning value is split across 0x2C (bits 15:0) and 0x30 (bits 31:16).
  - The current count reads at 0x18 (bits 15:0) and 0x1C (bits 31:16).
  - Each half sits in bits 15:0 of its word, and the upper bits read 0.
  - Control at 0x08 and gate at 0x14 read back as written.
- R5: An accepted write to 0x00, 0x04, 0x2C or 0x30 sets bit 4 of the status register at 0x10. That bit stays set for two slow ticks; a further such write restarts the count. On the second tick the bit clears, and the counter and early-warning threshold take the written values.
- R6: With control bit 1 set, each slow tick lowers a non-zero count by exactly one. With control bit 1 clear, the count is frozen.
- R7: When a decrement makes the count equal the early-warning value while control bit 0 is set, status bit 0 sets. irq is status bit 0 AND bit 0 of the gate register at 0x14.
- R8: When a decrement makes the count zero while control bit 3 is set, status bit 3 sets and rst_req goes high. The count then holds at zero until reloaded.
- R9: Writing 1 to bit 0 of 0x0C clears status bit 0. Writing 1 to bit 3 of 0x0C clears status bit 3.
- R10: Rewriting the load value while counting (keepalive) lets the count keep falling during the busy window. The count is then reloaded when the window closes.
- R11: Reads return current values while the block is locked.
- R12: With control bits 0 and 3 clear, reaching the threshold or zero sets no status bit, and irq and rst_req stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle pulse per counter step (32768 per second) |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Gated early-warning interrupt |
| rst_req | output | 1 | System reset request |

## Verification
On every cycle, the assertions check the following:
- a locked write leaves control and load state untouched;
- the count moves only by single steps, and only while enabled;
- the count never leaves zero except through a reload;
- the reset request rises only at zero;
- the busy window can neither close nor commit without a tick.

Only the bench scenarios can show the rest:
- the exact key comparison and relocking;
- the placement of halves in the address map;
- the two-tick length of the busy window and its reload on keepalive;
- threshold matches, interrupt gating, and clearing of status bits through the clear register.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    localparam int ADDR_W = 6;
    localparam logic [ADDR_W-1:0] OFS_LOAD_LO = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_LOAD_HI = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_CLEAR   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_GATE    = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO  = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_LOCK    = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_WARN_LO = 6'h2C;
    localparam logic [ADDR_W-1:0] OFS_WARN_HI = 6'h30;

    // control bit positions
    localparam int CB_WARN_EN = 0;
    localparam int CB_RUN     = 1;
    localparam int CB_NEWMODE = 2;
    localparam int CB_RST_EN  = 3;
    localparam int CTRL_W     = 4;

    // status bit positions (also used by the clear register)
    localparam int SB_WARN = 0;
    localparam int SB_RST  = 3;
    localparam int SB_BUSY = 4;
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int          DW  = 32,
    parameter logic [15:0] KEY = 16'hE551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic              unlocked,
    output logic [CTRL_W-1:0] ctrl,
    output logic              gate,
    output logic [DW-1:0]     load_sh,
    output logic [DW-1:0]     warn_sh,
    output logic              ld_wr,
    output logic              clr_warn,
    output logic              clr_rst
);
    localparam int HW = DW / 2;

    typedef struct packed {
        logic              unlocked;
        logic [CTRL_W-1:0] ctrl;
        logic              gate;
        logic [DW-1:0]     load;
        logic [DW-1:0]     warn;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d        = q;
        ld_wr    = 1'b0;
        clr_warn = 1'b0;
        clr_rst  = 1'b0;
        if (wr) begin
            if (addr == OFS_LOCK) begin
                d.unlocked = (wdata == {16'h0, KEY});
            end else if (q.unlocked) begin
                case (addr)
                    OFS_LOAD_LO: begin d.load[HW-1:0]  = wdata[HW-1:0]; ld_wr = 1'b1; end
                    OFS_LOAD_HI: begin d.load[DW-1:HW] = wdata[HW-1:0]; ld_wr = 1'b1; end
                    OFS_WARN_LO: begin d.warn[HW-1:0]  = wdata[HW-1:0]; ld_wr = 1'b1; end
                    OFS_WARN_HI: begin d.warn[DW-1:HW] = wdata[HW-1:0]; ld_wr = 1'b1; end
                    OFS_CTRL:    d.ctrl = wdata[CTRL_W-1:0];
                    OFS_GATE:    d.gate = wdata[0];
                    OFS_CLEAR: begin
                        clr_warn = wdata[SB_WARN];
                        clr_rst  = wdata[SB_RST];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign unlocked = q.unlocked;
    assign ctrl     = q.ctrl;
    assign gate     = q.gate;
    assign load_sh  = q.load;
    assign warn_sh  = q.warn;
endmodule

// File: rtl/kwdt_busy.sv
module kwdt_busy #(
    parameter int BUSY_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ld_wr,
    output logic busy,
    output logic commit
);
    localparam int BW = $clog2(BUSY_TICKS + 1);
    localparam logic [BW-1:0] LAST = BW'(BUSY_TICKS - 1);

    typedef struct packed {
        logic          busy;
        logic [BW-1:0] ticks;
    } busy_t;

    busy_t q, d;

    always_comb begin
        d      = q;
        commit = 1'b0;
        if (ld_wr) begin
            d.busy  = 1'b1;
            d.ticks = '0;
        end else if (q.busy && tick) begin
            if (q.ticks == LAST) begin
                commit  = 1'b1;
                d.busy  = 1'b0;
                d.ticks = '0;
            end else begin
                d.ticks = q.ticks + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
endmodule

// File: rtl/kwdt_count.sv
module kwdt_count
    import kwdt_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              commit,
    input  logic [DW-1:0]     load_sh,
    input  logic [DW-1:0]     warn_sh,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              clr_warn,
    input  logic              clr_rst,
    output logic [DW-1:0]     cnt,
    output logic              raw_warn,
    output logic              raw_rst
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] warn;
        logic          raw_warn;
        logic          raw_rst;
    } cnt_t;

    cnt_t q, d;
    logic [DW-1:0] dec;

    always_comb begin
        d   = q;
        dec = q.cnt - 1'b1;
        if (clr_warn) d.raw_warn = 1'b0;
        if (clr_rst)  d.raw_rst  = 1'b0;
        if (commit) begin
            d.cnt  = load_sh;
            d.warn = warn_sh;
        end else if (ctrl[CB_RUN] && tick && (q.cnt != '0)) begin
            d.cnt = dec;
            if (ctrl[CB_WARN_EN] && (dec == q.warn)) d.raw_warn = 1'b1;
            if (ctrl[CB_RST_EN]  && (dec == '0))     d.raw_rst  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt      = q.cnt;
    assign raw_warn = q.raw_warn;
    assign raw_rst  = q.raw_rst;
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int          DW         = 32,
    parameter int          BUSY_TICKS = 2,
    parameter logic [15:0] KEY        = 16'hE551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              rst_req
);
    localparam int HW = DW / 2;

    logic              unlocked, gate, ld_wr, clr_warn, clr_rst;
    logic              busy, commit, raw_warn, raw_rst;
    logic [CTRL_W-1:0] ctrl;
    logic [DW-1:0]     load_sh, warn_sh, cnt;

    kwdt_regs #(.DW(DW), .KEY(KEY)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .unlocked(unlocked), .ctrl(ctrl), .gate(gate), .load_sh(load_sh),
        .warn_sh(warn_sh), .ld_wr(ld_wr), .clr_warn(clr_warn), .clr_rst(clr_rst)
    );

    kwdt_busy #(.BUSY_TICKS(BUSY_TICKS)) u_busy (
        .clk(clk), .rst_n(rst_n), .tick(slow_tick), .ld_wr(ld_wr),
        .busy(busy), .commit(commit)
    );

    kwdt_count #(.DW(DW)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(slow_tick), .commit(commit),
        .load_sh(load_sh), .warn_sh(warn_sh), .ctrl(ctrl),
        .clr_warn(clr_warn), .clr_rst(clr_rst),
        .cnt(cnt), .raw_warn(raw_warn), .raw_rst(raw_rst)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_LOAD_LO: bus_rdata[HW-1:0] = load_sh[HW-1:0];
            OFS_LOAD_HI: bus_rdata[HW-1:0] = load_sh[DW-1:HW];
            OFS_WARN_LO: bus_rdata[HW-1:0] = warn_sh[HW-1:0];
            OFS_WARN_HI: bus_rdata[HW-1:0] = warn_sh[DW-1:HW];
            OFS_CNT_LO:  bus_rdata[HW-1:0] = cnt[HW-1:0];
            OFS_CNT_HI:  bus_rdata[HW-1:0] = cnt[DW-1:HW];
            OFS_CTRL:    bus_rdata[CTRL_W-1:0] = ctrl;
            OFS_GATE:    bus_rdata[0] = gate;
            OFS_LOCK:    bus_rdata[0] = unlocked;
            OFS_STATUS: begin
                bus_rdata[SB_WARN] = raw_warn;
                bus_rdata[SB_RST]  = raw_rst;
                bus_rdata[SB_BUSY] = busy;
            end
            default: ;
        endcase
    end

    assign irq     = raw_warn & gate;
    assign rst_req = raw_rst;
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          slow_tick,
    input logic          bus_wr,
    input logic [5:0]    bus_addr,
    input logic          unlocked,
    input logic [3:0]    ctrl,
    input logic [DW-1:0] load_sh,
    input logic [DW-1:0] cnt,
    input logic          commit,
    input logic          busy,
    input logic          rst_req
);
    AST_LOCKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && bus_wr && bus_addr != 6'h20) |=> ($stable(ctrl) && $stable(load_sh))); // R3
    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[1] && slow_tick && !commit && cnt != '0) |=> (cnt == $past(cnt) - DW'(1))); // R6
    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[1] && !commit) |=> $stable(cnt)); // R6
    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !commit) |=> (cnt == '0)); // R8
    AST_RST_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> (cnt == '0)); // R8
    AST_BUSY_WAITS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !slow_tick) |=> busy); // R5
    AST_COMMIT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (busy && slow_tick)); // R5
endmodule

bind kwdt_top kwdt_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .unlocked(unlocked), .ctrl(ctrl), .load_sh(load_sh),
    .cnt(cnt), .commit(commit), .busy(busy), .rst_req(rst_req)
);

// File: tb/kwdt_top_bench.sv
module kwdt_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, rst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    kwdt_top u_kwdt_top (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rst_req(rst_req)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_OUT = 2'd3;
    localparam int NV = 40;
    // fields: op, offset, write data, expected, requirement number
    localparam logic [79:0] VEC [NV] = '{
        {OP_RD,  6'h20, 32'h0,     32'h0,  8'd1},  // R1 locked
        {OP_RD,  6'h08, 32'h0,     32'h0,  8'd1},  // R1
        {OP_OUT, 6'h00, 32'h0,     32'h0,  8'd1},  // R1 outputs low
        {OP_WR,  6'h08, 32'hB,     32'h0,  8'd3},
        {OP_RD,  6'h08, 32'h0,     32'h0,  8'd3},  // R3 dropped
        {OP_WR,  6'h20, 32'hE551,  32'h0,  8'd2},
        {OP_RD,  6'h20, 32'h0,     32'h1,  8'd2},  // R2 unlocked
        {OP_WR,  6'h00, 32'h5,     32'h0,  8'd4},
        {OP_WR,  6'h04, 32'h0,     32'h0,  8'd4},
        {OP_WR,  6'h2C, 32'h3,     32'h0,  8'd4},
        {OP_WR,  6'h30, 32'h0,     32'h0,  8'd4},
        {OP_RD,  6'h10, 32'h0,     32'h10, 8'd5},  // R5 busy
        {OP_TK,  6'h00, 32'h0,     32'h0,  8'd5},
        {OP_RD,  6'h10, 32'h0,     32'h10, 8'd5},  // R5 still busy
        {OP_RD,  6'h18, 32'h0,     32'h0,  8'd5},  // R5 not yet taken
        {OP_TK,  6'h00, 32'h0,     32'h0,  8'd5},
        {OP_RD,  6'h10, 32'h0,     32'h0,  8'd5},  // R5 done
        {OP_RD,  6'h18, 32'h0,     32'h5,  8'd5},  // R5 taken
        {OP_WR,  6'h14, 32'h1,     32'h0,  8'd7},
        {OP_WR,  6'h08, 32'hB,     32'h0,  8'd4},
        {OP_RD,  6'h08, 32'h0,     32'hB,  8'd4},  // R4 ctrl readback
        {OP_TK,  6'h00, 32'h0,     32'h0,  8'd6},
        {OP_RD,  6'h18, 32'h0,     32'h4,  8'd6},  // R6
        {OP_TK,  6'h00, 32'h0,     32'h0,  8'd7},
        {OP_RD,  6'h10, 32'h0,     32'h1,  8'd7},  // R7 warning
        {OP_OUT, 6'h00, 32'h0,     32'h1,  8'd7},  // R7 irq
        {OP_WR,  6'h20, 32'h0,     32'h0,  8'd2},
        {OP_RD,  6'h18, 32'h0,     32'h3,  8'd11}, // R11 locked read
        {OP_WR,  6'h0C, 32'h1,     32'h0,  8'd3},
        {OP_RD,  6'h10, 32'h0,     32'h1,  8'd3},  // R3 clear dropped
        {OP_WR,  6'h20, 32'hE551,  32'h0,  8'd2},
        {OP_WR,  6'h0C, 32'h1,     32'h0,  8'd9},
        {OP_RD,  6'h10, 32'h0,     32'h0,  8'd9},  // R9
        {OP_TK,  6'h00, 32'h0,     32'h0,  8'd8},
        {OP_TK,  6'h00, 32'h0,     32'h0,  8'd8},
        {OP_TK,  6'h00, 32'h0,     32'h0,  8'd8},
        {OP_RD,  6'h10, 32'h0,     32'h8,  8'd8},  // R8 reset event
        {OP_OUT, 6'h00, 32'h0,     32'h2,  8'd8},  // R8 rst_req, no irq
        {OP_TK,  6'h00, 32'h0,     32'h0,  8'd8},
        {OP_RD,  6'h18, 32'h0,     32'h0,  8'd8}   // R8 holds zero
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input int req);
        @(negedge clk);
        bus_addr = a;
        #1 check(req, bus_rdata, exp);
    endtask

    task automatic tk();
        @(negedge clk);
        slow_tick = 1'b1;
        @(negedge clk);
        slow_tick = 1'b0;
    endtask

    task automatic outs(input logic [31:0] exp, input int req);
        @(negedge clk);
        #1 check(req, {30'h0, rst_req, irq}, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][79:78])
                OP_WR:   wr(VEC[i][77:72], VEC[i][71:40]);
                OP_RD:   rd(VEC[i][77:72], VEC[i][39:8], int'(VEC[i][7:0]));
                OP_TK:   tk();
                default: outs(VEC[i][39:8], int'(VEC[i][7:0]));
            endcase
        end
        // R9: clear reset event
        wr(6'h0C, 32'h8);
        rd(6'h10, 32'h0, 9);
        outs(32'h0, 9);
        // R4: split halves, 0x10002
        wr(6'h04, 32'h1);
        wr(6'h00, 32'hFFFF_0002);
        rd(6'h00, 32'h2, 4);
        tk(); tk();
        rd(6'h18, 32'h2, 4);
        rd(6'h1C, 32'h1, 4);
        // R6: freeze with run bit clear
        wr(6'h08, 32'h9);
        tk();
        rd(6'h18, 32'h2, 6);
        // R10: keepalive
        wr(6'h08, 32'hB);
        tk();
        rd(6'h18, 32'h1, 10);
        wr(6'h00, 32'h2);
        tk();
        rd(6'h1C, 32'h1, 10);
        rd(6'h18, 32'h0, 10);
        tk();
        rd(6'h18, 32'h2, 10);
        rd(6'h1C, 32'h1, 10);
        // R7: gate off masks irq while the warning bit is set
        wr(6'h14, 32'h0);
        wr(6'h2C, 32'h1);
        wr(6'h30, 32'h1);
        tk(); tk();
        tk();
        rd(6'h10, 32'h1, 7);
        outs(32'h0, 7);
        wr(6'h0C, 32'h1);
        // R12: events disabled, count to zero
        wr(6'h08, 32'h2);
        wr(6'h04, 32'h0);
        wr(6'h00, 32'h3);
        wr(6'h2C, 32'h2);
        wr(6'h30, 32'h0);
        tk(); tk();
        rd(6'h18, 32'h3, 12);
        tk(); tk(); tk();
        rd(6'h18, 32'h0, 12);
        rd(6'h10, 32'h0, 12);
        outs(32'h0, 12);
        // R2: a wrong key relocks
        wr(6'h20, 32'h1234);
        rd(6'h20, 32'h0, 2);
        wr(6'h20, 32'h1_E551);
        rd(6'h20, 32'h0, 2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1: watchdog expired, actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule